// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block stores incoming frames in a circular region of local packet memory. The memory is split into 256-byte pages. The ring covers the pages from a programmable first page up to, but not including, a programmable limit page. A byte stream from the receive path is written into the ring one byte per cycle. Each frame is placed behind a 4-byte header slot at the first free page. After the last byte of the frame has been stored, the header is filled in. The header gives the frame's status, the page where the next frame will start, and the stored byte count.

Software reads frames out of the memory over a separate path. It releases the pages it has consumed by moving a boundary pointer to the page just before the next unread frame. The block never writes into the boundary page. If a frame would need that page, the frame is dropped, the current-page pointer keeps its value, and a single-cycle overflow interrupt is raised. Frames that are too short or too long are discarded without using any pages.

Top module: `rx_page_ring`

## Requirements
- R1: After reset, the ring starts at page 0x40 and ends before page 0x80, the boundary equals the first page, and `cur_page` equals the first page plus one. A host write to the first page reloads the boundary and `cur_page` in the same way.
- R2: Data byte k of an accepted frame is written to memory address (cur_page*256 + 4 + k), with the page advancing across page ends. Each write appears on the memory port one cycle after the byte is accepted.
- R3: When a frame runs past the last ring page (limit page minus one), it continues at the first ring page.
- R4: The header occupies offsets 0 to 3 of the frame's first page, in this order: status, next-frame page, byte count low, byte count high. The byte count is the frame length plus 4.
- R5: The next-frame page is cur_page plus ceil((length+4)/256), wrapped into the ring. `cur_page` takes this value when the frame is committed.
- R6: The header bytes are written after the last data byte. `cur_page` changes on the same clock edge that issues the memory write of header byte 3.
- R7: The status byte is 0x01 (bit 0: frame intact) for a clean frame. It is 0x08 (bit 3: overrun) when `in_err` was high on any byte of the frame.
- R8: No memory write ever targets the boundary page. A frame that would need the boundary page is dropped, `ovf_irq` pulses high for exactly one cycle, and `cur_page` is unchanged.
- R9: Frames shorter than 60 bytes or longer than 1518 bytes are discarded. For such frames no header is written, `cur_page` is unchanged, and no interrupt is raised. Frames of exactly 60 and exactly 1518 bytes are accepted.
- R10: `ring_empty` is high exactly when (boundary+1), wrapped from the limit page back to the first page, equals `cur_page`.
- R11: The host register select codes are: 0 = first page (which also reinitialises), 1 = limit page, 2 = boundary, 3 = current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Host register select (0 first, 1 limit, 2 boundary, 3 current) |
| cfg_wdata | input | 8 | Host write data (page number) |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_err | input | 1 | Receive overrun flag for the frame |
| in_data | input | 8 | Frame byte |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | 8 | Current-page pointer |
| ring_empty | output | 1 | No unread frame in the ring |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
A corrupted write pointer shows up as data bytes at the wrong addresses within one cycle of the affected byte. An error in the page-advance logic shows up first at a page end or at the wrap point. A wrong next-page calculation appears as an incorrect header byte 1 and an incorrect `cur_page` about four cycles after the frame ends. It then causes every later frame to be placed at the wrong address. A broken boundary compare either lets a write reach the protected page within one cycle, or drops a frame that should have fit. Either case is visible in `ovf_irq` and `cur_page` right after the frame's last byte.

// File: rtl/rx_page_ring.sv
`timescale 1ns/1ps
module rx_page_ring #(
  parameter int PG_W      = 8,
  parameter int OFF_W     = 8,
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 60,
  parameter int MAX_LEN   = 1518,
  parameter int RST_START = 'h40,
  parameter int RST_STOP  = 'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [PG_W-1:0]    cfg_wdata,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic               in_err,
  input  logic [7:0]         in_data,
  output logic               mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  output logic [PG_W-1:0]    cur_page,
  output logic               ring_empty,
  output logic               ovf_irq
);
  localparam int HDR_BYTES = 4;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_HDR} st_t;
  st_t st;

  logic [PG_W-1:0]  start_pg, stop_pg, bnd_pg, cur_pg, wa_pg, nxt_pg;
  logic [OFF_W-1:0] wa_off;
  logic [LEN_W-1:0] len;
  logic             full, long_f, err;
  logic [1:0]       hcnt;
  logic [15:0]      hdr_cnt;
  logic [7:0]       stat, hdr_byte;

  function automatic logic [PG_W-1:0] pg_inc(input logic [PG_W-1:0] p);
    logic [PG_W-1:0] q;
    q = p + 1'b1;
    return (q == stop_pg) ? start_pg : q;
  endfunction

  logic             byte_go, fresh, blk, over, full_now, long_now, err_now, do_wr, bad_len;
  logic [PG_W-1:0]  tgt_pg, adv_pg;
  logic [OFF_W-1:0] tgt_off;
  logic [LEN_W-1:0] cnt_now, len_now;

  assign fresh    = (st == S_IDLE);
  assign byte_go  = in_valid && ((st == S_RECV) || (fresh && in_sof));
  assign tgt_pg   = fresh ? cur_pg : wa_pg;
  assign tgt_off  = fresh ? OFF_W'(HDR_BYTES) : wa_off;
  assign blk      = (tgt_pg == bnd_pg);
  assign cnt_now  = fresh ? '0 : len;
  assign over     = (cnt_now >= LEN_W'(MAX_LEN));
  assign full_now = (!fresh && full) || blk;
  assign long_now = (!fresh && long_f) || over;
  assign err_now  = (!fresh && err) || in_err;
  assign len_now  = over ? cnt_now : cnt_now + 1'b1;
  assign do_wr    = byte_go && !full_now && !over;
  assign adv_pg   = (&tgt_off) ? pg_inc(tgt_pg) : tgt_pg;
  assign bad_len  = long_now || (len_now < LEN_W'(MIN_LEN));

  always_comb begin
    case (hcnt)
      2'd0:    hdr_byte = stat;
      2'd1:    hdr_byte = 8'(nxt_pg);
      2'd2:    hdr_byte = hdr_cnt[7:0];
      default: hdr_byte = hdr_cnt[15:8];
    endcase
  end

  assign cur_page   = cur_pg;
  assign ring_empty = (pg_inc(bnd_pg) == cur_pg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      start_pg  <= PG_W'(RST_START);
      stop_pg   <= PG_W'(RST_STOP);
      bnd_pg    <= PG_W'(RST_START);
      cur_pg    <= PG_W'(RST_START + 1);
      wa_pg     <= '0;
      wa_off    <= '0;
      nxt_pg    <= '0;
      len       <= '0;
      full      <= 1'b0;
      long_f    <= 1'b0;
      err       <= 1'b0;
      hcnt      <= '0;
      hdr_cnt   <= '0;
      stat      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ovf_irq   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      ovf_irq <= 1'b0;
      case (st)
        S_IDLE, S_RECV: if (byte_go) begin
          mem_we    <= do_wr;
          mem_addr  <= {tgt_pg, tgt_off};
          mem_wdata <= in_data;
          wa_pg     <= adv_pg;
          wa_off    <= tgt_off + 1'b1;
          len       <= len_now;
          full      <= full_now;
          long_f    <= long_now;
          err       <= err_now;
          if (!in_eof) st <= S_RECV;
          else if (bad_len) st <= S_IDLE;
          else if (full_now) begin
            ovf_irq <= 1'b1;
            st      <= S_IDLE;
          end else begin
            st      <= S_HDR;
            nxt_pg  <= pg_inc(tgt_pg);
            hdr_cnt <= 16'(len_now) + 16'd4;
            stat    <= err_now ? 8'h08 : 8'h01;
            hcnt    <= '0;
          end
        end
        S_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= {cur_pg, OFF_W'(hcnt)};
          mem_wdata <= hdr_byte;
          hcnt      <= hcnt + 1'b1;
          if (hcnt == 2'd3) begin
            cur_pg <= nxt_pg;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            start_pg <= cfg_wdata;
            bnd_pg   <= cfg_wdata;
            cur_pg   <= cfg_wdata + 1'b1;
          end
          2'd1:    stop_pg <= cfg_wdata;
          2'd2:    bnd_pg  <= cfg_wdata;
          default: cur_pg  <= cfg_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_page_ring_chk.sv
`timescale 1ns/1ps
module rx_page_ring_chk #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [PG_W-1:0]         bnd_pg,
  input logic [PG_W-1:0]         cur_pg,
  input logic                    mem_we,
  input logic [PG_W+OFF_W-1:0]   mem_addr,
  input logic                    ovf_irq
);
  a_r8_no_bnd_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[PG_W+OFF_W-1:OFF_W] != $past(bnd_pg)));

  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);

  a_r8_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq && !$past(cfg_we)) |-> $stable(cur_pg));

  a_r6_cur_with_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_pg) && !$past(cfg_we)) |->
      (mem_we && mem_addr == {$past(cur_pg), OFF_W'(3)}));
endmodule

bind rx_page_ring rx_page_ring_chk #(.PG_W(PG_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .bnd_pg(bnd_pg),
  .cur_pg(cur_pg), .mem_we(mem_we), .mem_addr(mem_addr), .ovf_irq(ovf_irq)
);

// File: tb/rx_page_ring_tb.sv
`timescale 1ns/1ps
module rx_page_ring_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = '0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  cur_page;
  logic        ring_empty, ovf_irq;

  always #10 clk = ~clk;

  rx_page_ring u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .in_data(in_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_page(cur_page),
    .ring_empty(ring_empty), .ovf_irq(ovf_irq)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] mem [int];
  int seq_of [int];
  int wr_seq = 0, ovf_cnt = 0, watch_cnt = 0;
  logic [7:0] watch_pg = 8'hFF;
  logic [7:0] prev_cur = '0;
  logic       chg_we = 0;
  logic [15:0] chg_addr = '0;
  int ring_lo = 'h40, ring_hi = 'h80;

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      wr_seq++;
      mem[int'(mem_addr)] = mem_wdata;
      seq_of[int'(mem_addr)] = wr_seq;
      if (mem_addr[15:8] == watch_pg) watch_cnt++;
    end
    if (ovf_irq) ovf_cnt++;
    if (cur_page != prev_cur) begin
      chg_we = mem_we;
      chg_addr = mem_addr;
    end
    prev_cur = cur_page;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pwrap(input int p);
    return (p + 1 == ring_hi) ? ring_lo : p + 1;
  endfunction

  function automatic int raddr(input int pg, input int off);
    int p = pg;
    for (int i = 0; i < off / 256; i++) p = pwrap(p);
    return p * 256 + off % 256;
  endfunction

  function automatic int memrd(input int a);
    return mem.exists(a) ? int'(mem[a]) : -1;
  endfunction

  task automatic cfg(input int sel, input int val);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 0;
    if (sel == 0) ring_lo = val;
    if (sel == 1) ring_hi = val;
  endtask

  task automatic send(input int n, input int seed, input bit errmid);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_err = errmid && (i == n / 2); in_data = 8'(i * 3 + seed);
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input int pg, input int n,
                             input int seed, input int st);
    int nx = pg;
    for (int i = 0; i < (n + 4 + 255) / 256; i++) nx = pwrap(nx);
    chk({tag, " R4 status R7"}, memrd(pg * 256 + 0), st);
    chk({tag, " R4/R5 next page"}, memrd(pg * 256 + 1), nx);
    chk({tag, " R4 count low"}, memrd(pg * 256 + 2), (n + 4) & 255);
    chk({tag, " R4 count high"}, memrd(pg * 256 + 3), (n + 4) >> 8);
    chk({tag, " R2 first byte"}, memrd(raddr(pg, 4)), (seed) & 255);
    chk({tag, " R2 last byte"}, memrd(raddr(pg, 4 + n - 1)), ((n - 1) * 3 + seed) & 255);
    chk({tag, " R5 cur_page"}, int'(cur_page), nx);
  endtask

  task automatic t_reset();
    chk("R1 reset cur_page", int'(cur_page), 'h41);
    chk("R1/R10 reset empty", int'(ring_empty), 1);
    chk("R1 reset mem_we", int'(mem_we), 0);
    chk("R8 reset ovf", int'(ovf_irq), 0);
  endtask

  task automatic t_basic();
    send(100, 1, 0);
    check_frame("basic100", 'h41, 100, 1, 'h01);
    chk("R10 not empty", int'(ring_empty), 0);
    send(252, 2, 0);
    check_frame("fit252", 'h42, 252, 2, 'h01);
    send(253, 3, 0);
    check_frame("spill253", 'h43, 253, 3, 'h01);
  endtask

  task automatic t_order();
    int pg = int'(cur_page);
    send(80, 5, 0);
    chk("R6 header after data", int'(seq_of[pg * 256] > seq_of[raddr(pg, 4 + 79)]), 1);
    chk("R6 cur change with header byte3", int'(chg_we && chg_addr == 16'(pg * 256 + 3)), 1);
  endtask

  task automatic t_err();
    int pg = int'(cur_page);
    send(70, 7, 1);
    check_frame("errframe", pg, 70, 7, 'h08);
  endtask

  task automatic t_limits();
    int o;
    cfg(0, 'h40);
    chk("R1/R11 reinit cur_page", int'(cur_page), 'h41);
    chk("R1 reinit empty", int'(ring_empty), 1);
    mem.delete();
    o = ovf_cnt;
    send(59, 4, 0);
    chk("R9 short cur unchanged", int'(cur_page), 'h41);
    chk("R9 short no header", int'(mem.exists('h4100)), 0);
    send(1519, 4, 0);
    chk("R9 long cur unchanged", int'(cur_page), 'h41);
    chk("R9 long no header", int'(mem.exists('h4100)), 0);
    chk("R9 no interrupt", ovf_cnt - o, 0);
    send(60, 6, 0);
    check_frame("min60 R9", 'h41, 60, 6, 'h01);
    send(1518, 8, 0);
    check_frame("max1518 R9", 'h42, 1518, 8, 'h01);
  endtask

  task automatic t_wrap();
    cfg(1, 'h44);
    cfg(0, 'h40);
    cfg(2, 'h42);
    cfg(3, 'h43);
    chk("R11 current write", int'(cur_page), 'h43);
    chk("R10 empty at bnd+1", int'(ring_empty), 1);
    send(300, 9, 0);
    check_frame("wrap300", 'h43, 300, 9, 'h01);
    chk("R3 byte 252 at first page", memrd('h4000), (252 * 3 + 9) & 255);
  endtask

  task automatic t_ovf();
    int o = ovf_cnt;
    watch_pg = 8'h42; watch_cnt = 0;
    send(300, 11, 0);
    chk("R8 drop cur unchanged", int'(cur_page), 'h41);
    chk("R8 one irq pulse", ovf_cnt - o, 1);
    chk("R8 no write to boundary page", watch_cnt, 0);
    cfg(3, 'h42);
    send(100, 12, 0);
    chk("R8 start at boundary cur", int'(cur_page), 'h42);
    chk("R8 second irq pulse", ovf_cnt - o, 2);
    chk("R8 no write to boundary page 2", watch_cnt, 0);
    watch_pg = 8'hFF;
  endtask

  task automatic t_empty_wrap();
    cfg(2, 'h43);
    cfg(3, 'h40);
    chk("R10 empty across wrap", int'(ring_empty), 1);
    cfg(3, 'h41);
    chk("R10 not empty across wrap", int'(ring_empty), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_err();
    t_limits();
    t_wrap();
    t_ovf();
    t_empty_wrap();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule